// File: doc/BRIEF.md
# Legacy memory attribute decoder

This block sorts CPU accesses to the lowest megabyte of the address space into three outcomes: the access is served by DRAM with full read and write rights, it is served by DRAM with writes suppressed, or it is passed on to the PCI side. It applies the same decision to every access, one access per clock, and gives a registered verdict one cycle later. The verdict is a 2-bit target code and a flag that tells the memory path to drop a write.

The decision comes from a small configuration space. Seven attribute bytes split the 0xC0000–0xFFFFF range into one 64 KB upper window and twelve 16 KB windows. Each window takes a 2-bit code. A separate control byte, together with a system-management-mode input, decides whether the 0xA0000–0xBFFFF graphics window is backed by DRAM. A read-only byte reports the installed memory size, which is fixed by a parameter. Software writes the configuration bytes through a simple byte-wide port. The same port reads any byte back one cycle later.

Top module: `lmad_top`

## Requirements
- R1: After reset the seven attribute bytes (offsets 0x59–0x5F) read 0x00, the control byte at offset 0x72 reads 0x02, all thirteen attribute windows decode to PCI, and res_valid is low.
- R2: Addresses 0xF0000–0xFFFFF take their 2-bit code from bits 5:4 of offset 0x59.
- R3: Twelve 16 KB windows start at 0xC0000. Window j (0..11) covers 0xC0000+0x4000·j up to 0xC3FFF+0x4000·j. It takes its code from offset 0x5A+j/2: bits 1:0 for even j, bits 5:4 for odd j.
- R4: Code 3 gives target 2'b01 (DRAM, read/write). Code 1 gives target 2'b10 (DRAM, read-only). Codes 0 and 2 give target 2'b00 (PCI).
- R5: res_wr_blocked is 1 only for a write whose target is 2'b10. Reads of such a window and writes anywhere else give 0.
- R6: Addresses 0xA0000–0xBFFFF give target 2'b01 when either bit 6 of offset 0x72 is set, or smm_active and bit 3 of offset 0x72 are both high. Otherwise they give 2'b00. smm_active is sampled together with the access.
- R7: Offset 0x57 reads DRAM_MB/8, saturated at 255. Writes to 0x57 and to any offset other than 0x59–0x5F and 0x72 change nothing, and such offsets read 0x00.
- R8: An access presented with acc_valid in one cycle produces res_valid, res_target and res_wr_blocked in the next cycle. A configuration write affects every access presented after its clock edge. Configuration bytes hold their value when no write hits them.
- R9: Addresses below 0xA0000, and any address at or above 0x100000, give target 2'b01.
- R10: Attribute and control bytes store and read back all 8 bits written. Bits other than the decoded ones do not change the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset for write and read-back |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered read-back of the byte at cfg_addr |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W (32) | Access byte address |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| smm_active | input | 1 | CPU is in system management mode |
| res_valid | output | 1 | Verdict for the access of the previous cycle is valid |
| res_target | output | 2 | 00 PCI, 01 DRAM read/write, 10 DRAM read-only |
| res_wr_blocked | output | 1 | The previous-cycle write must not update DRAM |

## Verification
Some rules are checked by the assertions on every cycle. A blocked write always carries the read-only target and always comes from a write access. The graphics window never reaches DRAM while both of its enabling conditions are off. Configuration bytes never move without a hit on a writable offset, and they come out of reset at their defined values. The bench scenarios cover the rest: the exact mapping of each of the twelve windows to its byte and nibble, the window boundary addresses, the meaning of each of the four codes, the saturated memory-size value, and the point at which a new setting first governs an access.

// File: rtl/lmad_pkg.sv
package lmad_pkg;

  localparam int CFG_AW         = 8;
  localparam int CFG_DW         = 8;
  localparam int ATTR_W         = 2;
  localparam int NUM_ATTR_BYTES = 7;
  localparam int NUM_REGIONS    = 13;
  localparam int LOW_W          = 20;
  localparam int SEG_SHIFT      = 14;
  localparam int SEG_W          = 4;
  localparam int MB_PER_UNIT    = 8;

  // configuration offsets (fixed by software convention)
  localparam int OFS_MEMSIZE    = 'h57;
  localparam int OFS_ATTR_BASE  = 'h59;
  localparam int OFS_ATTR_LAST  = OFS_ATTR_BASE + NUM_ATTR_BYTES - 1;
  localparam int OFS_SMRAM      = 'h72;

  localparam logic [CFG_DW-1:0] ATTR_RST  = 8'h00;
  localparam logic [CFG_DW-1:0] SMRAM_RST = 8'h02;

  // legacy window boundaries
  localparam int SMRAM_LO  = 'hA0000;
  localparam int SEG_LO    = 'hC0000;
  localparam int UPPER_LO  = 'hF0000;
  localparam int SMRAM_HI  = 'hBFFFF;

  localparam int SMRAM_BIT_SMM  = 3;
  localparam int SMRAM_BIT_OPEN = 6;

  typedef enum logic [1:0] {
    TGT_PCI     = 2'b00,
    TGT_DRAM    = 2'b01,
    TGT_DRAM_RO = 2'b10
  } tgt_e;

  typedef logic [NUM_ATTR_BYTES-1:0][CFG_DW-1:0] attr_bytes_t;
  typedef logic [NUM_REGIONS-1:0][ATTR_W-1:0]    region_attr_t;

  function automatic tgt_e code_to_tgt(input logic [ATTR_W-1:0] code);
    case (code)
      2'b11:   return TGT_DRAM;
      2'b01:   return TGT_DRAM_RO;
      default: return TGT_PCI;
    endcase
  endfunction

endpackage

// File: rtl/lmad_cfg_regs.sv
module lmad_cfg_regs
  import lmad_pkg::*;
#(
  parameter int DRAM_MB = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output attr_bytes_t       attr_bytes,
  output logic [CFG_DW-1:0] smram_q,
  output logic [CFG_DW-1:0] cfg_rdata
);

  localparam int SIZE_UNITS = DRAM_MB / MB_PER_UNIT;
  localparam int SIZE_MAX   = (1 << CFG_DW) - 1;
  localparam logic [CFG_DW-1:0] SIZE_VAL =
    CFG_DW'((SIZE_UNITS > SIZE_MAX) ? SIZE_MAX : SIZE_UNITS);

  localparam logic [CFG_AW-1:0] A_SMRAM = CFG_AW'(OFS_SMRAM);
  localparam logic [CFG_AW-1:0] A_SIZE  = CFG_AW'(OFS_MEMSIZE);
  localparam logic [CFG_AW-1:0] A_LO    = CFG_AW'(OFS_ATTR_BASE);
  localparam logic [CFG_AW-1:0] A_HI    = CFG_AW'(OFS_ATTR_LAST);

  logic [CFG_DW-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      attr_bytes <= '{default: ATTR_RST};
      smram_q    <= SMRAM_RST;
    end else if (cfg_we) begin
      for (int k = 0; k < NUM_ATTR_BYTES; k++) begin
        if (cfg_addr == CFG_AW'(OFS_ATTR_BASE + k)) attr_bytes[k] <= cfg_wdata;
      end
      if (cfg_addr == A_SMRAM) smram_q <= cfg_wdata;
    end
  end

  always_comb begin
    rd_next = '0;
    if (cfg_addr == A_SIZE)  rd_next = SIZE_VAL;
    if (cfg_addr == A_SMRAM) rd_next = smram_q;
    for (int k = 0; k < NUM_ATTR_BYTES; k++) begin
      if (cfg_addr == CFG_AW'(OFS_ATTR_BASE + k)) rd_next = attr_bytes[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_next;
  end

  AST_CFG_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (smram_q == SMRAM_RST) && (attr_bytes == '0)); // R1

  AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (cfg_addr < A_LO || cfg_addr > A_HI) && cfg_addr != A_SMRAM)
      |=> $stable(attr_bytes) && $stable(smram_q)); // R7

  AST_CFG_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(attr_bytes) && $stable(smram_q)); // R8

endmodule

// File: rtl/lmad_attr_unpack.sv
module lmad_attr_unpack
  import lmad_pkg::*;
(
  input  attr_bytes_t  bytes_in,
  output region_attr_t region_code
);

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    if (r == 0) begin : g_upper
      assign region_code[r] = bytes_in[0][5:4];
    end else begin : g_seg
      localparam int SRC_BYTE = 1 + (r - 1) / 2;
      if (((r - 1) % 2) == 1) begin : g_odd
        assign region_code[r] = bytes_in[SRC_BYTE][5:4];
      end else begin : g_even
        assign region_code[r] = bytes_in[SRC_BYTE][1:0];
      end
    end
  end

  // bits carried for read-back only
  logic [NUM_ATTR_BYTES-1:0] unused_bits;
  for (genvar k = 0; k < NUM_ATTR_BYTES; k++) begin : g_spare
    if (k == 0) begin : g_first
      assign unused_bits[k] = ^{bytes_in[k][7:6], bytes_in[k][3:0]};
    end else begin : g_rest
      assign unused_bits[k] = ^{bytes_in[k][7:6], bytes_in[k][3:2]};
    end
  end

endmodule

// File: rtl/lmad_addr_decode.sv
module lmad_addr_decode
  import lmad_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic              smm_active,
  input  logic              smram_smm_en,
  input  logic              smram_force_en,
  input  region_attr_t      region_code,
  output tgt_e              target,
  output logic              wr_blocked
);

  logic             above_1m;
  logic [LOW_W-1:0] low;
  logic [SEG_W-1:0] seg;
  logic [SEG_W-1:0] ridx;
  logic             smram_open;

  assign above_1m   = (addr >> LOW_W) != '0;
  assign low        = addr[LOW_W-1:0];
  assign seg        = SEG_W'((low - LOW_W'(SEG_LO)) >> SEG_SHIFT);
  assign ridx       = seg + SEG_W'(1);
  assign smram_open = (smm_active && smram_smm_en) || smram_force_en;

  always_comb begin
    target = TGT_DRAM;
    if (!above_1m) begin
      if (low >= LOW_W'(UPPER_LO)) begin
        target = code_to_tgt(region_code[0]);
      end else if (low >= LOW_W'(SEG_LO)) begin
        target = code_to_tgt(region_code[ridx]);
      end else if (low >= LOW_W'(SMRAM_LO)) begin
        target = smram_open ? TGT_DRAM : TGT_PCI;
      end
    end
  end

  assign wr_blocked = is_write && (target == TGT_DRAM_RO);

endmodule

// File: rtl/lmad_top.sv
module lmad_top
  import lmad_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DRAM_MB = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              smm_active,
  output logic              res_valid,
  output logic [1:0]        res_target,
  output logic              res_wr_blocked
);

  attr_bytes_t       attr_bytes;
  logic [CFG_DW-1:0] smram_q;
  region_attr_t      region_code;
  tgt_e              dec_target;
  logic              dec_blocked;

  lmad_cfg_regs #(.DRAM_MB(DRAM_MB)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .attr_bytes (attr_bytes),
    .smram_q    (smram_q),
    .cfg_rdata  (cfg_rdata)
  );

  lmad_attr_unpack u_unpack (
    .bytes_in    (attr_bytes),
    .region_code (region_code)
  );

  lmad_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr           (acc_addr),
    .is_write       (acc_write),
    .smm_active     (smm_active),
    .smram_smm_en   (smram_q[SMRAM_BIT_SMM]),
    .smram_force_en (smram_q[SMRAM_BIT_OPEN]),
    .region_code    (region_code),
    .target         (dec_target),
    .wr_blocked     (dec_blocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid      <= 1'b0;
      res_target     <= TGT_PCI;
      res_wr_blocked <= 1'b0;
    end else begin
      res_valid      <= acc_valid;
      res_target     <= dec_target;
      res_wr_blocked <= acc_valid && dec_blocked;
    end
  end

  logic unused_smram;
  assign unused_smram = ^{smram_q[7], smram_q[5:4], smram_q[2:0]};

  AST_BLOCK_IMPLIES_RO: assert property (@(posedge clk) disable iff (rst)
    res_wr_blocked |-> res_target == TGT_DRAM_RO); // R5

  AST_BLOCK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    res_wr_blocked |-> $past(acc_write) && $past(acc_valid)); // R5

  AST_SMRAM_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (res_valid
     && $past(acc_addr) >= ADDR_W'(SMRAM_LO) && $past(acc_addr) <= ADDR_W'(SMRAM_HI)
     && !$past(smram_q[SMRAM_BIT_OPEN])
     && !($past(smm_active) && $past(smram_q[SMRAM_BIT_SMM])))
    |-> res_target == TGT_PCI); // R6

endmodule

// File: tb/lmad_top_tb_top.sv
`timescale 1ns/1ps
module lmad_top_tb_top;

  localparam int AW = 32;

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    tgt;
    logic          blk;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_addr = 8'h00;
  logic [7:0]    cfg_wdata = 8'h00;
  logic [7:0]    cfg_rdata, sat_rdata;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_write = 1'b0;
  logic          smm_active = 1'b0;
  logic          res_valid, res_wr_blocked;
  logic [1:0]    res_target;
  logic          sat_valid, sat_blk;
  logic [1:0]    sat_tgt;

  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb[$];
  logic [7:0] mreg [0:255];

  always #2 clk = ~clk;

  lmad_top #(.ADDR_W(AW), .DRAM_MB(512)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .smm_active(smm_active),
    .res_valid(res_valid), .res_target(res_target),
    .res_wr_blocked(res_wr_blocked));

  lmad_top #(.ADDR_W(AW), .DRAM_MB(4096)) dut_sat_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(sat_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .smm_active(smm_active),
    .res_valid(sat_valid), .res_target(sat_tgt), .res_wr_blocked(sat_blk));

  function automatic logic [1:0] code_tgt(input logic [1:0] c);
    if (c == 2'd3) return 2'b01;
    if (c == 2'd1) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [1:0] model_tgt(input logic [AW-1:0] a, input logic smm);
    logic [7:0] b;
    int j;
    if (a >= 32'h100000) return 2'b01;
    if (a >= 32'hF0000) return code_tgt(mreg[8'h59][5:4]);
    if (a >= 32'hC0000) begin
      j = int'((a - 32'hC0000) >> 14);
      b = mreg[8'h5A + j / 2];
      return code_tgt((j % 2 == 1) ? b[5:4] : b[1:0]);
    end
    if (a >= 32'hA0000)
      return (mreg[8'h72][6] || (smm && mreg[8'h72][3])) ? 2'b01 : 2'b00;
    return 2'b01;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if ((a >= 8'h59 && a <= 8'h5F) || a == 8'h72) mreg[a] = d;
  endtask

  task automatic cfg_read(input logic [7:0] a, input string tag);
    logic [7:0] e;
    cfg_addr = a;
    @(negedge clk);
    e = mreg[a];
    check(cfg_rdata == e, tag, $sformatf("rdata@%0h", a), cfg_rdata, e);
  endtask

  task automatic access(input logic [AW-1:0] a, input logic wr, input logic smm,
                        input string tag);
    exp_t it;
    logic [1:0] t;
    t = model_tgt(a, smm);
    it.addr = a; it.tgt = t; it.blk = wr && (t == 2'b10); it.tag = tag;
    sb.push_back(it);
    acc_valid = 1'b1; acc_addr = a; acc_write = wr; smm_active = smm;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  // monitor: pops the scoreboard as verdicts appear
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8", "unexpected res_valid", 1, 0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        check(res_target == it.tgt && res_wr_blocked == it.blk, it.tag,
              $sformatf("verdict@%0h {tgt,blk}", it.addr),
              {res_target, res_wr_blocked}, {it.tgt, it.blk});
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mreg[i] = 8'h00;
    mreg[8'h72] = 8'h02;
    mreg[8'h57] = 8'd64;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);

    // R1 reset values and R7 size register
    for (int k = 8'h59; k <= 8'h5F; k++) cfg_read(8'(k), "R1");
    cfg_read(8'h72, "R1");
    cfg_read(8'h57, "R7");
    check(sat_rdata == 8'd255, "R7", "saturated size", sat_rdata, 255);
    access(32'hF0000, 1'b0, 1'b0, "R1");
    access(32'hC0000, 1'b1, 1'b0, "R1");
    access(32'hEC000, 1'b0, 1'b0, "R1");
    access(32'hA0000, 1'b0, 1'b1, "R1");
    // R9 outside the windows
    access(32'h00000, 1'b1, 1'b0, "R9");
    access(32'h9FFFF, 1'b0, 1'b0, "R9");
    access(32'h100000, 1'b1, 1'b0, "R9");
    access(32'hFFF0000, 1'b0, 1'b0, "R9");

    // R2 upper window, all codes; R4 and R5
    cfg_write(8'h59, 8'h30);
    access(32'hF0000, 1'b1, 1'b0, "R2");
    access(32'hFFFFF, 1'b0, 1'b0, "R4");
    cfg_write(8'h59, 8'h10);
    access(32'hF8000, 1'b1, 1'b0, "R5");
    access(32'hF8000, 1'b0, 1'b0, "R5");
    cfg_write(8'h59, 8'h20);
    access(32'hFFFFF, 1'b1, 1'b0, "R4");
    // R10 other bits leave the decode alone
    cfg_write(8'h59, 8'hCF);
    cfg_read(8'h59, "R10");
    access(32'hF0000, 1'b1, 1'b0, "R10");

    // R3 twelve windows, every code, both ends of each
    for (int p = 0; p < 6; p++) begin
      int c0, c1;
      c0 = (2 * p * 3 + 1) % 4;
      c1 = ((2 * p + 1) * 3 + 1) % 4;
      cfg_write(8'(8'h5A + p), 8'(c0 | (c1 << 4) | 8'h88));
    end
    for (int j = 0; j < 12; j++) begin
      access(32'hC0000 + 32'(j) * 32'h4000, 1'b1, 1'b0, "R3");
      access(32'hC3FFF + 32'(j) * 32'h4000, 1'b0, 1'b0, "R3");
      access(32'hC1000 + 32'(j) * 32'h4000, 1'b1, 1'b1, "R5");
    end
    cfg_read(8'h5C, "R10");

    // R6 graphics window
    cfg_write(8'h72, 8'h08);
    access(32'hA0000, 1'b0, 1'b0, "R6");
    access(32'hBFFFF, 1'b1, 1'b1, "R6");
    cfg_write(8'h72, 8'h40);
    access(32'hB0000, 1'b1, 1'b0, "R6");
    cfg_write(8'h72, 8'h00);
    access(32'hA0000, 1'b0, 1'b1, "R6");
    cfg_write(8'h72, 8'h08);
    access(32'hAFFFF, 1'b0, 1'b1, "R8");
    access(32'hAFFFF, 1'b0, 1'b0, "R8");
    cfg_read(8'h72, "R10");

    // R7 stray writes
    cfg_write(8'h57, 8'h11);
    cfg_write(8'h58, 8'hFF);
    cfg_write(8'h60, 8'hFF);
    cfg_read(8'h57, "R7");
    cfg_read(8'h58, "R7");
    cfg_read(8'h60, "R7");
    for (int k = 8'h59; k <= 8'h5F; k++) cfg_read(8'(k), "R7");
    access(32'hF0000, 1'b1, 1'b0, "R7");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R8", "missing verdicts", sb.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule